// File: doc/BRIEF.md
# 8b/10b Line Encoder

This block turns one byte per clock into a 10-bit code group with bounded run length and DC balance, ready for a serializer. A select input chooses whether the byte is sent as a data character or as one of the twelve special control characters. The encoder keeps a running disparity bit. For each code group it picks the form that drives the running sum of ones and zeros back toward balance. The disparity is updated after the 6-bit sub-block and again after the 4-bit sub-block.

The byte and the select are sampled on every rising clock edge. The matching code group appears on the output register after that same edge, so the latency is one cycle. There is no idle state: every edge consumes a character. An asynchronous active-low reset clears all state. Its release is synchronized inside the block, so encoding starts a fixed number of edges after `rst_n` rises. A select request for a byte that is not a legal control character is encoded as the data character with the same byte value, and an error flag is raised alongside that code group.

Top module: `lc_enc8b10b`

## Requirements
- R1: The byte and select present at a rising edge produce their code group on `dout` and `ctl_err` right after that edge. The outputs do not change between edges.
- R2: Driving `rst_n` low clears `dout` to 0 and `ctl_err` to 0 at once, without a clock, and sets the running disparity negative. After `rst_n` rises, the outputs stay at 0 for SYNC_STAGES edges, and the next edge encodes.
- R3: Field layout: `din[4:0]` is x and `din[7:5]` is y of character D.x.y. `dout[9:4]` is abcdei and `dout[3:0]` is fghj, with bit a (`dout[9]`) sent first. Examples: D21.5 gives 1010101010 at either disparity. D0.0 gives 1001110100 at negative disparity and 0110001011 at positive disparity.
- R4: Every code group contains 4, 5 or 6 ones.
- R5: At negative running disparity a group holds at least 5 ones; at positive disparity it holds at most 5. After a group with 6 ones the disparity is positive, after 4 ones it is negative, and after 5 ones it is unchanged.
- R6: With `ctl_sel`=1, exactly these bytes are legal: K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. K28.5 gives 0011111010 at negative disparity and 1100000101 at positive disparity. K28.0 at negative disparity gives 0011110100. K23.7 at negative disparity gives 1110101000. K28.7 at negative disparity gives 0011111000.
- R7: For D.x.7 the alternate fghj form 0111/1000 is used when x is 17, 18 or 20 at negative disparity (after the 6-bit part), or when x is 11, 13 or 14 at positive disparity. Examples: D17.7 gives 1000110111 at negative and 1000110001 at positive disparity. D11.7 gives 1101001000 at positive and 1101001110 at negative disparity.
- R8: With `ctl_sel`=1 and an illegal byte, the group equals the data encoding of that byte and `ctl_err` is 1 for that group. For example, 0x01 at negative disparity gives 0111010100. Otherwise `ctl_err` is 0.
- R9: The transmitted bit stream, taken across group boundaries, never holds more than 5 equal bits in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| din | input | 8 | Byte to encode: y in [7:5], x in [4:0] |
| ctl_sel | input | 1 | 1 requests a control character, 0 a data character |
| dout | output | 10 | Code group abcdei fghj, bit 9 sent first |
| ctl_err | output | 1 | The group came from an illegal control request |

## Verification
The assertions assume that every clock edge after the reset synchronizer releases carries a meaningful character. They also assume that `din` and `ctl_sel` are stable around the rising edge. The stimulus changes inputs only on the falling edge. While in reset and during release it holds a balanced character, D21.5, so any extra captures leave the disparity untouched and the expected stream stays aligned. Disparity and run-length properties are checked on the output stream itself, so the long sweep over all 256 data bytes and all 12 control bytes depends on no table.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;
  localparam int C6_W   = 6;
  localparam int C4_W   = CODE_W - C6_W;

  localparam logic RD_NEG = 1'b0;
  localparam logic RD_POS = 1'b1;

  localparam logic [X_W-1:0] X_COMMA = 5'd28;
  localparam logic [Y_W-1:0] Y_SEVEN = 3'd7;

  // legal special characters: x=28 with any y, or y=7 with x in {23,27,29,30}
  function automatic logic ctl_legal(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
    return (x == X_COMMA) ||
           ((y == Y_SEVEN) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction
endpackage

// File: rtl/lc_rst_sync.sv
`timescale 1ns/1ps
module lc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sh_q[STAGES-1];

  initial begin
    a_r2_stage_min: assert (STAGES >= 2);
  end
endmodule

// File: rtl/lc_enc6.sv
`timescale 1ns/1ps
module lc_enc6
  import lc_pkg::*;
(
  input  logic [X_W-1:0]  x,
  input  logic            k28,
  input  logic            rd_in,
  output logic [C6_W-1:0] c6,
  output logic            rd_out
);
  logic [C6_W-1:0] base;
  logic            unbal;
  logic            flip;

  // negative-disparity form, abcdei with a in bit 5
  always_comb begin
    unique case (x)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = k28 ? 6'b001111 : 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
    unbal  = ($countones(base) != 3);
    // x=7 is balanced but still has two forms
    flip   = (rd_in == RD_POS) && (unbal || (x == 5'd7));
    c6     = flip ? ~base : base;
    rd_out = unbal ? ~rd_in : rd_in;
  end
endmodule

// File: rtl/lc_enc4.sv
`timescale 1ns/1ps
module lc_enc4
  import lc_pkg::*;
(
  input  logic [Y_W-1:0]  y,
  input  logic [X_W-1:0]  x,
  input  logic            ctl,
  input  logic            rd_in,
  output logic [C4_W-1:0] c4,
  output logic            rd_out
);
  logic [C4_W-1:0] base;
  logic            alt;
  logic            unbal;
  logic            flip;

  always_comb begin
    alt = ((rd_in == RD_NEG) && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
          ((rd_in == RD_POS) && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    if (ctl) begin
      unique case (y)
        3'd0: base = 4'b1011;
        3'd1: base = 4'b0110;
        3'd2: base = 4'b1010;
        3'd3: base = 4'b1100;
        3'd4: base = 4'b1101;
        3'd5: base = 4'b0101;
        3'd6: base = 4'b1001;
        default: base = 4'b0111;
      endcase
    end else begin
      unique case (y)
        3'd0: base = 4'b1011;
        3'd1: base = 4'b1001;
        3'd2: base = 4'b0101;
        3'd3: base = 4'b1100;
        3'd4: base = 4'b1101;
        3'd5: base = 4'b1010;
        3'd6: base = 4'b0110;
        default: base = alt ? 4'b0111 : 4'b1110;
      endcase
    end
    unbal  = ($countones(base) != 2);
    // control forms always swap at positive disparity; data y=3 is balanced yet swaps
    flip   = (rd_in == RD_POS) && (ctl || unbal || (y == 3'd3));
    c4     = flip ? ~base : base;
    rd_out = unbal ? ~rd_in : rd_in;
  end
endmodule

// File: rtl/lc_enc8b10b.sv
`timescale 1ns/1ps
module lc_enc8b10b
  import lc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  input  logic              ctl_sel,
  output logic [CODE_W-1:0] dout,
  output logic              ctl_err
);
  logic            rst_q_n;
  logic [X_W-1:0]  x;
  logic [Y_W-1:0]  y;
  logic            legal;
  logic            use_k;
  logic            k28;
  logic            rd_q;
  logic            rd_mid;
  logic            rd_nxt;
  logic [C6_W-1:0] c6;
  logic [C4_W-1:0] c4;
  logic            err_nxt;

  lc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    x       = din[X_W-1:0];
    y       = din[BYTE_W-1:X_W];
    legal   = ctl_legal(x, y);
    use_k   = ctl_sel && legal;
    k28     = use_k && (x == X_COMMA);
    err_nxt = ctl_sel && !legal;
  end

  lc_enc6 u_enc6 (
    .x      (x),
    .k28    (k28),
    .rd_in  (rd_q),
    .c6     (c6),
    .rd_out (rd_mid)
  );

  lc_enc4 u_enc4 (
    .y      (y),
    .x      (x),
    .ctl    (use_k),
    .rd_in  (rd_mid),
    .c4     (c4),
    .rd_out (rd_nxt)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dout    <= '0;
      ctl_err <= 1'b0;
      rd_q    <= RD_NEG;
    end else begin
      dout    <= {c6, c4};
      ctl_err <= err_nxt;
      rd_q    <= rd_nxt;
    end
  end

  a_r4_weight: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($countones({c6, c4}) >= 4) && ($countones({c6, c4}) <= 6));

  a_r5_six_neg: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_q == RD_NEG) |-> ($countones(c6) >= 3));

  a_r5_six_pos: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_q == RD_POS) |-> ($countones(c6) <= 3));

  a_r5_rd_follows_out: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($countones(dout) != 5) |-> (rd_q == ($countones(dout) > 5)));

  a_r6_comma_six: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_sel && din[X_W-1:0] == X_COMMA) |-> (c6 == 6'b001111 || c6 == 6'b110000));

  a_r7_alt_neg: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_sel && din == 8'hF1 && rd_mid == RD_NEG) |-> (c4 == 4'b0111));

  a_r8_data_no_err: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctl_sel |=> !ctl_err);
endmodule

// File: tb/lc_enc8b10b_tb.sv
`timescale 1ns/1ps
module lc_enc8b10b_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk;
  logic       rst_n;
  logic [7:0] din;
  logic       ctl_sel;
  logic [9:0] dout;
  logic       ctl_err;

  int   checks = 0;
  int   errs   = 0;
  logic brd;       // bench running disparity, 1 = positive
  int   run;
  logic lastb;
  logic [9:0] prev;

  lc_enc8b10b #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .ctl_sel(ctl_sel),
    .dout(dout), .ctl_err(ctl_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk10(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stream_clear();
    brd = 1'b0; run = 0; lastb = 1'b0;
  endtask

  // disparity, weight and run checks on each new group (R4, R5, R9)
  task automatic observe();
    int ones;
    int maxrun;
    ones = $countones(dout);
    chk_int("R4 weight in 4..6", (ones >= 4 && ones <= 6) ? 1 : 0, 1);
    if (brd) chk_int("R5 ones at positive rd <= 5", (ones <= 5) ? 1 : 0, 1);
    else     chk_int("R5 ones at negative rd >= 5", (ones >= 5) ? 1 : 0, 1);
    if (ones != 5) brd = (ones > 5);
    maxrun = 0;
    for (int i = 9; i >= 0; i--) begin
      if (run == 0 || dout[i] != lastb) run = 1;
      else run++;
      lastb = dout[i];
      if (run > maxrun) maxrun = run;
    end
    chk_int("R9 run length <= 5", (maxrun <= 5) ? 1 : 0, 1);
    prev = dout;
  endtask

  task automatic send(input logic [7:0] d, input logic k);
    @(negedge clk);
    din = d; ctl_sel = k;
    #1;
    chk10("R1 no change before edge", dout, prev);
    @(posedge clk);
    #1;
    observe();
  endtask

  task automatic send_exp(input string req, input logic [7:0] d, input logic k,
                          input logic [9:0] exp, input logic err);
    send(d, k);
    chk10(req, dout, exp);
    chk10({req, " err flag"}, {9'd0, ctl_err}, {9'd0, err});
  endtask

  task automatic t_reset();
    rst_n = 1'b1; din = 8'hB5; ctl_sel = 1'b0;
    #3 rst_n = 1'b0;
    #1;
    chk10("R2 async clear dout", dout, 10'd0);
    chk10("R2 async clear err", {9'd0, ctl_err}, 10'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk10("R2 release held", dout, 10'd0);
    repeat (SYNC + 1) @(posedge clk);
    #1;
    chk10("R2 encodes after release", dout, 10'b1010101010);
    stream_clear();
    prev = dout;
  endtask

  task automatic t_ctrl_comma();
    send_exp("R6 K28.5 neg", 8'hBC, 1'b1, 10'b0011111010, 1'b0);
    send_exp("R6 K28.5 pos", 8'hBC, 1'b1, 10'b1100000101, 1'b0);
  endtask

  task automatic t_data_vectors();
    send_exp("R3 D21.5", 8'hB5, 1'b0, 10'b1010101010, 1'b0);
    send_exp("R3 D0.0 neg", 8'h00, 1'b0, 10'b1001110100, 1'b0);
    send_exp("R6 K28.5 neg again", 8'hBC, 1'b1, 10'b0011111010, 1'b0);
    send_exp("R3 D0.0 pos", 8'h00, 1'b0, 10'b0110001011, 1'b0);
    send_exp("R6 K28.5 pos again", 8'hBC, 1'b1, 10'b1100000101, 1'b0);
  endtask

  task automatic t_alt7();
    send_exp("R7 D17.7 neg", 8'hF1, 1'b0, 10'b1000110111, 1'b0);
    send_exp("R7 D11.7 pos", 8'hEB, 1'b0, 10'b1101001000, 1'b0);
    send_exp("R7 D11.7 neg", 8'hEB, 1'b0, 10'b1101001110, 1'b0);
    send_exp("R7 D17.7 pos", 8'hF1, 1'b0, 10'b1000110001, 1'b0);
  endtask

  task automatic t_ctrl_misc();
    send_exp("R6 K23.7 neg", 8'hF7, 1'b1, 10'b1110101000, 1'b0);
    send_exp("R6 K28.0 neg", 8'h1C, 1'b1, 10'b0011110100, 1'b0);
  endtask

  task automatic t_illegal();
    send_exp("R8 illegal 0x01", 8'h01, 1'b1, 10'b0111010100, 1'b1);
    send_exp("R8 err clears on data", 8'hB5, 1'b0, 10'b1010101010, 1'b0);
    send_exp("R6 K28.7 neg legal", 8'hFC, 1'b1, 10'b0011111000, 1'b0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 256; i++) begin
      send(i[7:0], 1'b0);
      chk10("R8 data sweep err low", {9'd0, ctl_err}, 10'd0);
    end
    for (int j = 0; j < 12; j++) begin
      logic [7:0] kb;
      if (j < 8) kb = {j[2:0], 5'd28};
      else begin
        case (j)
          8:  kb = 8'hF7;
          9:  kb = 8'hFB;
          10: kb = 8'hFD;
          default: kb = 8'hFE;
        endcase
      end
      send(kb, 1'b1);
      chk10("R6 legal control err low", {9'd0, ctl_err}, 10'd0);
    end
  endtask

  task automatic t_reset_mid();
    if (!brd) send(8'hBC, 1'b1);
    @(negedge clk);
    din = 8'hB5; ctl_sel = 1'b0;
    rst_n = 1'b0;
    #1;
    chk10("R2 mid-run async clear", dout, 10'd0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (SYNC + 2) @(posedge clk);
    #1;
    stream_clear();
    prev = dout;
    send_exp("R2 rd negative after reset", 8'hBC, 1'b1, 10'b0011111010, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    stream_clear();
    prev = '0;
    t_reset();
    t_ctrl_comma();
    t_data_vectors();
    t_alt7();
    t_ctrl_misc();
    t_illegal();
    t_sweep();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule